// File: doc/BRIEF.md
# ADC Conversion Sequencer Timing Controller

This block is the digital timing core of a successive-approximation converter. A trigger starts a series of conversion slots, numbered from 0 up to a programmed last slot. Each slot holds the sample-hold line high for a programmable acquisition window. The converter then runs a fixed conversion phase, and the stubbed converter data is captured into that slot's result register. The analog converter is not modelled. Its output is taken as data that must be valid on the result-present cycle.

With overlap allowed, the next slot's window runs while the current conversion is still in progress. With the non-overlap bit set, each window waits until the pending conversion has delivered its result. A window that closes exactly on the previous conversion's result-present cycle can corrupt that result, so the block raises a collision flag. The block also supports a dual-channel mode that stores an A and a B result per slot, and an option to drop the first slot's results. A trigger that arrives during a series is rejected and reported. The configuration inputs are captured when a trigger is accepted.

Top module: `adc_seq_timer`

## Requirements
- R1: After reset, sampleHold, seqDone, collision and overflow are 0, and every result valid bit is 0.
- R2: A trigger accepted at a clock edge raises sampleHold in the very next cycle. Each window lasts acqWin+1 cycles. Over a series, sampleHold is high for (lastSlot+1)*(acqWin+1) cycles in total.
- R3: Cycle k after a window's last cycle is conversion cycle k. Conversion covers cycles 1 to 13. The converter data inputs are captured on cycle 14, and the slot's result register and valid bit show them from cycle 15. Slots are served in ascending order.
- R4: When nonOverlap is 0, the next slot's window starts on conversion cycle max(7, 13-acqWin) of the previous slot.
- R5: When nonOverlap is 1, the next slot's window starts on cycle 15 of the previous slot. No window runs while a conversion is in progress.
- R6: collision is set when a window's last cycle coincides with a result-present cycle. It stays set until the next accepted trigger. With overlap, this happens only for acqWin=7.
- R7: When simulMode is 1, convDataB is stored in resultB and resultValidB is set for each reported slot. When simulMode is 0, resultValidB stays 0.
- R8: When discardFirst is 1, slot 0 writes no result. Its valid bits stay 0 and its previous values are kept. Later slots are reported normally.
- R9: A trigger that arrives while a series is running is ignored, and the timing and results are unchanged. It sets overflow, which clears on the next accepted trigger.
- R10: seqDone is high for exactly one cycle: the cycle in which the last slot's result first appears. Results hold their values after the series ends. An accepted trigger clears all valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | Starts a series when idle |
| lastSlot | input | SLOT_W | Index of the final slot in a series |
| acqWin | input | ACQ_W | Acquisition setting; window is acqWin+1 cycles |
| nonOverlap | input | 1 | 1: sample only after the pending conversion finishes |
| simulMode | input | 1 | 1: store A and B channels per slot |
| discardFirst | input | 1 | 1: drop the results of slot 0 |
| convDataA | input | DATA_W | Stub converter output, channel A |
| convDataB | input | DATA_W | Stub converter output, channel B |
| sampleHold | output | 1 | Sample-hold control, high during a window |
| resultA | output | NUM_SLOTS x DATA_W | Per-slot channel A results |
| resultB | output | NUM_SLOTS x DATA_W | Per-slot channel B results |
| resultValidA | output | NUM_SLOTS | Channel A result written in this series |
| resultValidB | output | NUM_SLOTS | Channel B result written in this series |
| seqDone | output | 1 | One-cycle end-of-series pulse |
| collision | output | 1 | Window ended on a result-present cycle |
| overflow | output | 1 | Trigger arrived during a series |

## Verification
The bench sweeps every acquisition setting from 0 to 15 against every slot count in both overlap modes, and toggles dual-channel and discard across the sweep. The converter stub returns the current cycle number, so each stored value shows the exact capture cycle. The time to seqDone shows the start point of each window. Short settings separate the delayed start from the fixed conversion-cycle-7 start. The setting of 7 separates collision detection from the settings 6 and 8 next to it, and the non-overlap runs show that the flag stays clear there. A run with a trigger fired in the middle of a series confirms that it is rejected. Discard runs check that slot 0 keeps its previous contents.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // Strobes from the sequencer to the result storage
  typedef struct packed {
    logic clear;   // new series accepted: drop valid bits
    logic writeA;  // capture channel A into wrSlot
    logic writeB;  // capture channel B into wrSlot
  } dpStrobe_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int ACQ_W       = 4,
  parameter int CONV_CYCLES = 13,
  parameter int OVL_START   = 7,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CNT_W  = $clog2(CONV_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigger,
  input  logic [SLOT_W-1:0] lastSlot,
  input  logic [ACQ_W-1:0]  acqWin,
  input  logic              nonOverlap,
  input  logic              simulMode,
  input  logic              discardFirst,
  output logic              sampleHold,
  output dpStrobe_t         strobe,
  output logic [SLOT_W-1:0] wrSlot,
  output logic              seqDone,
  output logic              collision,
  output logic              overflow
);
  logic              busy;
  logic [SLOT_W-1:0] cfgLast;
  logic [ACQ_W-1:0]  cfgAcq;
  logic              cfgNonOvl, cfgSimul, cfgDiscard;
  logic              sampling;
  logic [ACQ_W-1:0]  sampLeft;
  logic [SLOT_W-1:0] sampSlot;
  logic [SLOT_W:0]   issueNext;
  logic              convActive;
  logic [CNT_W-1:0]  convCnt;
  logic [SLOT_W-1:0] convSlot;
  logic              presentValid;
  logic [SLOT_W-1:0] presentSlot;

  logic             accept, sampEnd, moreSlots, ovlStart, nolStart, nextStart, lastLatch;
  logic [CNT_W-1:0] startCnt;

  // conversion cycle before the one on which the next window opens
  always_comb begin
    if (int'(cfgAcq) >= CONV_CYCLES - OVL_START) startCnt = CNT_W'(OVL_START - 1);
    else startCnt = CNT_W'(CONV_CYCLES - 1 - int'(cfgAcq));
  end

  assign accept    = trigger && !busy;
  assign sampEnd   = sampling && (sampLeft == '0);
  assign moreSlots = issueNext <= {1'b0, cfgLast};
  assign ovlStart  = !cfgNonOvl && convActive && (convCnt == startCnt);
  assign nolStart  = cfgNonOvl && presentValid;
  assign nextStart = busy && !sampling && moreSlots && (ovlStart || nolStart);
  assign lastLatch = presentValid && (presentSlot == cfgLast);

  assign sampleHold    = sampling;
  assign wrSlot        = presentSlot;
  assign strobe.clear  = accept;
  assign strobe.writeA = presentValid && !(cfgDiscard && presentSlot == '0);
  assign strobe.writeB = strobe.writeA && cfgSimul;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; cfgLast <= '0; cfgAcq <= '0;
      cfgNonOvl <= 1'b0; cfgSimul <= 1'b0; cfgDiscard <= 1'b0;
      sampling <= 1'b0; sampLeft <= '0; sampSlot <= '0; issueNext <= '0;
      convActive <= 1'b0; convCnt <= '0; convSlot <= '0;
      presentValid <= 1'b0; presentSlot <= '0;
      seqDone <= 1'b0; collision <= 1'b0; overflow <= 1'b0;
    end else begin
      if (accept) begin
        busy       <= 1'b1;
        cfgLast    <= lastSlot;
        cfgAcq     <= acqWin;
        cfgNonOvl  <= nonOverlap;
        cfgSimul   <= simulMode;
        cfgDiscard <= discardFirst;
        sampling   <= 1'b1;
        sampLeft   <= acqWin;
        sampSlot   <= '0;
        issueNext  <= (SLOT_W+1)'(1);
        collision  <= 1'b0;
        overflow   <= 1'b0;
      end else begin
        if (trigger) overflow <= 1'b1;
        if (nextStart) begin
          sampling  <= 1'b1;
          sampLeft  <= cfgAcq;
          sampSlot  <= issueNext[SLOT_W-1:0];
          issueNext <= issueNext + (SLOT_W+1)'(1);
        end else if (sampEnd) begin
          sampling <= 1'b0;
        end else if (sampling) begin
          sampLeft <= sampLeft - ACQ_W'(1);
        end
        if (sampEnd && presentValid) collision <= 1'b1;
        if (lastLatch) busy <= 1'b0;
      end
      // converter phase tracking
      if (sampEnd) begin
        convActive <= 1'b1;
        convCnt    <= CNT_W'(1);
        convSlot   <= sampSlot;
      end else if (convActive) begin
        if (convCnt == CNT_W'(CONV_CYCLES)) convActive <= 1'b0;
        else convCnt <= convCnt + CNT_W'(1);
      end
      presentValid <= convActive && (convCnt == CNT_W'(CONV_CYCLES));
      presentSlot  <= convSlot;
      seqDone      <= lastLatch;
    end
  end

  // R2: no window outside a series
  p_no_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sampling);
  // R5: in non-overlap mode a window never runs beside a conversion
  p_nonovl_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgNonOvl && convActive) |-> !sampling);
  // R6: window end on a present cycle is flagged
  p_collision_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sampEnd && presentValid) |=> collision);
  // R9: a trigger during a series is reported
  p_overflow_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && trigger) |=> overflow);
  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 12,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  dpStrobe_t                         strobe,
  input  logic [SLOT_W-1:0]                 wrSlot,
  input  logic [DATA_W-1:0]                 dataA,
  input  logic [DATA_W-1:0]                 dataB,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]  resultA,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]  resultB,
  output logic [NUM_SLOTS-1:0]              validA,
  output logic [NUM_SLOTS-1:0]              validB
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [DATA_W-1:0] regA, regB;
    logic              vA, vB;
    logic              hit;
    assign hit = (wrSlot == SLOT_W'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regA <= '0; regB <= '0; vA <= 1'b0; vB <= 1'b0;
      end else if (strobe.clear) begin
        vA <= 1'b0; vB <= 1'b0;
      end else if (hit) begin
        if (strobe.writeA) begin regA <= dataA; vA <= 1'b1; end
        if (strobe.writeB) begin regB <= dataB; vB <= 1'b1; end
      end
    end

    assign resultA[s] = regA;
    assign resultB[s] = regB;
    assign validA[s]  = vA;
    assign validB[s]  = vB;
  end

  // R10: an accepted trigger leaves no valid bit set
  p_clear_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (validA == '0 && validB == '0));
  // R10: results hold when nothing is written
  p_hold_results_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.writeA && !strobe.writeB) |=> ($stable(resultA) && $stable(resultB)));
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int DATA_W      = 12,
  parameter int ACQ_W       = 4,
  parameter int CONV_CYCLES = 13,
  parameter int OVL_START   = 7,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             trigger,
  input  logic [SLOT_W-1:0]                lastSlot,
  input  logic [ACQ_W-1:0]                 acqWin,
  input  logic                             nonOverlap,
  input  logic                             simulMode,
  input  logic                             discardFirst,
  input  logic [DATA_W-1:0]                convDataA,
  input  logic [DATA_W-1:0]                convDataB,
  output logic                             sampleHold,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] resultA,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] resultB,
  output logic [NUM_SLOTS-1:0]             resultValidA,
  output logic [NUM_SLOTS-1:0]             resultValidB,
  output logic                             seqDone,
  output logic                             collision,
  output logic                             overflow
);
  dpStrobe_t         strobe;
  logic [SLOT_W-1:0] wrSlot;

  adc_seq_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .ACQ_W(ACQ_W),
    .CONV_CYCLES(CONV_CYCLES), .OVL_START(OVL_START)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .trigger(trigger), .lastSlot(lastSlot),
    .acqWin(acqWin), .nonOverlap(nonOverlap), .simulMode(simulMode),
    .discardFirst(discardFirst), .sampleHold(sampleHold), .strobe(strobe),
    .wrSlot(wrSlot), .seqDone(seqDone), .collision(collision), .overflow(overflow)
  );

  adc_seq_dp #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrSlot(wrSlot),
    .dataA(convDataA), .dataB(convDataB),
    .resultA(resultA), .resultB(resultB),
    .validA(resultValidA), .validB(resultValidB)
  );
endmodule

// File: tb/adc_seq_timer_bench.sv
module adc_seq_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigger = 1'b0;
  logic [1:0] lastSlot = '0;
  logic [3:0] acqWin = '0;
  logic nonOverlap = 1'b0, simulMode = 1'b0, discardFirst = 1'b0;
  logic [DW-1:0] convDataA, convDataB;
  logic sampleHold, seqDone, collision, overflow;
  logic [NS-1:0][DW-1:0] resultA, resultB;
  logic [NS-1:0] resultValidA, resultValidB;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // stub converter returns the cycle number, so captured values reveal timing
  assign convDataA = cyc[DW-1:0];
  assign convDataB = cyc[DW-1:0] ^ 12'hFFF;

  adc_seq_timer u_adc_seq_timer (
    .clk(clk), .rstN(rstN), .trigger(trigger), .lastSlot(lastSlot),
    .acqWin(acqWin), .nonOverlap(nonOverlap), .simulMode(simulMode),
    .discardFirst(discardFirst), .convDataA(convDataA), .convDataB(convDataB),
    .sampleHold(sampleHold), .resultA(resultA), .resultB(resultB),
    .resultValidA(resultValidA), .resultValidB(resultValidB),
    .seqDone(seqDone), .collision(collision), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0d)", req, act, exp, cyc);
    end
  endtask

  task automatic runSeries(input int acq, input int last, input bit nol,
                           input bit sim, input bit disc, input bit extra);
    int e [NS];
    int gap, doneExp, doneCyc, holdCnt, t0;
    bit colExp;
    logic [NS-1:0][DW-1:0] prevA;
    prevA = resultA;
    gap = nol ? 15 : ((13 - acq) > 7 ? (13 - acq) : 7);
    @(negedge clk);
    acqWin = 4'(acq); lastSlot = 2'(last);
    nonOverlap = nol; simulMode = sim; discardFirst = disc;
    trigger = 1'b1;
    t0 = cyc;
    e[0] = t0 + acq + 1;
    for (int n = 1; n < NS; n++) e[n] = e[n-1] + gap + acq;
    doneExp = e[last] + 15;
    colExp  = (last >= 1) && !nol && (gap + acq == 14);
    doneCyc = -1;
    holdCnt = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      trigger = 1'b0;
      if (extra && cyc == t0 + 3) trigger = 1'b1;
      if (cyc == t0 + 1) check(sampleHold == 1'b1, "R2 window opens", int'(sampleHold), 1);
      if (sampleHold) holdCnt++;
      if (seqDone) begin doneCyc = cyc; break; end
    end
    check(doneCyc == doneExp, nol ? "R5 done cycle" : "R4 done cycle", doneCyc, doneExp);
    check(holdCnt == (last + 1) * (acq + 1), "R2 hold cycles", holdCnt, (last + 1) * (acq + 1));
    check(collision == colExp, "R6 collision", int'(collision), int'(colExp));
    check(overflow == extra, "R9 overflow", int'(overflow), int'(extra));
    for (int n = 0; n < NS; n++) begin
      if (n > last) begin
        check(resultValidA[n] == 1'b0, "R10 unused slot invalid", int'(resultValidA[n]), 0);
      end else if (disc && n == 0) begin
        check(resultValidA[0] == 1'b0 && resultValidB[0] == 1'b0, "R8 slot0 dropped",
              int'({resultValidA[0], resultValidB[0]}), 0);
        check(resultA[0] == prevA[0], "R8 slot0 kept", int'(resultA[0]), int'(prevA[0]));
      end else begin
        check(resultValidA[n] == 1'b1, "R3 valid", int'(resultValidA[n]), 1);
        check(resultA[n] == DW'(e[n] + 14), "R3 captured value A", int'(resultA[n]),
              int'(DW'(e[n] + 14)));
        check(resultValidB[n] == sim, "R7 B valid", int'(resultValidB[n]), int'(sim));
        if (sim)
          check(resultB[n] == (DW'(e[n] + 14) ^ 12'hFFF), "R7 captured value B",
                int'(resultB[n]), int'(DW'(e[n] + 14) ^ 12'hFFF));
      end
    end
    @(negedge clk);
    check(seqDone == 1'b0, "R10 done single pulse", int'(seqDone), 1'b0);
    prevA = resultA;
    repeat (3) @(negedge clk);
    check(resultA == prevA, "R10 results hold", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sampleHold == 1'b0 && seqDone == 1'b0, "R1 reset outputs",
          int'({sampleHold, seqDone}), 0);
    check(collision == 1'b0 && overflow == 1'b0, "R1 reset flags",
          int'({collision, overflow}), 0);
    check(resultValidA == '0 && resultValidB == '0, "R1 reset valid",
          int'({resultValidA, resultValidB}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int acq = 0; acq < 16; acq++)
      for (int last = 0; last < NS; last++)
        for (int nol = 0; nol < 2; nol++)
          runSeries(acq, last, nol[0], 1'((acq + last) % 2), (acq % 3) == 0,
                    (acq == 5 && last == 2));
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule